// File: doc/BRIEF.md
# Halfword Long Branch-and-Link Sequencer

This block fetches a stream of 16-bit instructions through a three-stage fetch, decode and execute pipeline. It recognises only the two-halfword long call. Every other halfword retires in one cycle as a no-op. The first half of the pair adds the fetch address to a sign-extended high offset and parks the sum in the link register. The second half adds a low offset to that partial sum to form the target. It then flushes the pipeline, jumps to the target, writes the return address and trims it by two.

The memory side is a plain request interface with address, access size, read/write, request, sequential marker and opcode-fetch qualifier. The addressed halfword comes back on the same cycle and is captured into decode at the closing clock edge. The fetch address therefore runs four bytes ahead of the executing instruction.

Top module: `thumb_bl_seq`

## Requirements
- R1: While reset is low and in the first cycle after release, addr_o equals RESET_VEC, lr_o is 0 and seq_o is 0.
- R2: In every cycle, size_o is 2'b01, wr_o is 0, req_no is 0 and opc_no is 0.
- R3: When no call is executing, each cycle fetches the previous address plus 2 with seq_o = 1.
- R4: A halfword whose bits [15:11] are 5'b11110 sets lr_o at the end of its execute cycle to (its own address + 4) + (sign-extended bits [10:0] shifted left by 12).
- R5: In the execute cycle of a halfword whose bits [15:11] are 5'b11111, addr_o is that halfword's address + 4 and seq_o is 0.
- R6: In the next cycle, addr_o is the target, lr_o + (zero-extended bits [10:0] shifted left by 1), with seq_o = 1. At that cycle's end, lr_o takes the second halfword's address + 4.
- R7: In the cycle after that, addr_o is target + 2 with seq_o = 1, and lr_o drops by 2 at its end. It then equals the address that follows the pair.
- R8: The fetch after the refill is target + 4 with seq_o = 1. The halfword at the target is the next one executed.
- R9: A halfword whose bits [15:12] are not 4'b1111 leaves lr_o unchanged.
- R10: All address and link arithmetic wraps modulo 2^32, so negative high offsets give backward targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rdata_i | input | 16 | Halfword returned for addr_o |
| addr_o | output | 32 | Fetch address (program counter) |
| size_o | output | 2 | Access size, 01 = halfword |
| wr_o | output | 1 | Write strobe, 0 = read |
| req_no | output | 1 | Memory request, active low |
| seq_o | output | 1 | Sequential access marker |
| opc_no | output | 1 | Opcode fetch qualifier, active low |
| lr_o | output | 32 | Link register |

## Verification
The refill cycle's link decrement can collide with the execution of the target halfword when the target is itself the first half of another call. The decrement lands at the refill edge, and the new partial sum overwrites it one edge later. The bench provokes this by placing a second pair at the forward target, whose high offset is negative. It then follows lr_o through both writes in consecutive cycles and checks the backward wrap target and the loop back into the same pair.

// File: rtl/thumb_bl_pkg.sv
package thumb_bl_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_TGT    = 2'd1,
    ST_REFILL = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    PIPE_LOAD  = 2'd0,
    PIPE_FLUSH = 2'd1,
    PIPE_PRIME = 2'd2
  } pipe_op_e;
endpackage

// File: rtl/thumb_bl_pipe.sv
module thumb_bl_pipe
  import thumb_bl_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pipe_op_e      op_i,
  input  logic [IW-1:0] rdata_i,
  output logic [IW-1:0] ex_o,
  output logic          ex_v_o
);
  logic [IW-1:0] dec_q, ex_q;
  logic          dec_v_q, ex_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= '0;
      ex_q    <= '0;
      dec_v_q <= 1'b0;
      ex_v_q  <= 1'b0;
    end else begin
      unique case (op_i)
        PIPE_FLUSH: begin
          dec_v_q <= 1'b0;
          ex_v_q  <= 1'b0;
        end
        PIPE_PRIME: begin
          dec_q   <= rdata_i;
          dec_v_q <= 1'b1;
          ex_v_q  <= 1'b0;
        end
        default: begin
          ex_q    <= dec_q;
          ex_v_q  <= dec_v_q;
          dec_q   <= rdata_i;
          dec_v_q <= 1'b1;
        end
      endcase
    end
  end

  assign ex_o   = ex_q;
  assign ex_v_o = ex_v_q;

  // flushed stages hold nothing executable (R5)
  assert_flush_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == PIPE_FLUSH |=> !ex_v_q && !dec_v_q);
  // the halfword primed at the target reaches execute after the refill (R8)
  assert_prime_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == PIPE_PRIME |=> ##1 (ex_q == $past(rdata_i, 2)) && ex_v_q);
endmodule

// File: rtl/thumb_bl_link.sv
module thumb_bl_link
  import thumb_bl_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int OW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_st_e       st_i,
  input  logic [AW-1:0] fa_i,
  input  logic [IW-1:0] ex_i,
  input  logic          ex_v_i,
  output logic          br_hi_o,
  output logic          br_lo_o,
  output logic [AW-1:0] tgt_o,
  output logic [AW-1:0] lr_o
);
  localparam int HI_SH = OW + 1;
  localparam int GW    = IW - OW - 1;

  logic [AW-1:0] lr_q, ret_q, hi_add, lo_add;
  logic [OW-1:0] off;
  logic          grp;

  assign off     = ex_i[OW-1:0];
  assign grp     = ex_v_i && (ex_i[IW-1:OW+1] == {GW{1'b1}});
  assign br_hi_o = grp && !ex_i[OW];
  assign br_lo_o = grp && ex_i[OW];
  assign hi_add  = {{(AW-HI_SH-OW){off[OW-1]}}, off, {HI_SH{1'b0}}};
  assign lo_add  = {{(AW-OW-1){1'b0}}, off, 1'b0};
  assign tgt_o   = lr_q + lo_add;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q  <= '0;
      ret_q <= '0;
    end else begin
      unique case (st_i)
        ST_RUN: begin
          if (br_hi_o) lr_q <= fa_i + hi_add;
          if (br_lo_o) ret_q <= fa_i;
        end
        ST_TGT:    lr_q <= ret_q;
        ST_REFILL: lr_q <= lr_q - AW'(2);
        default:   ;
      endcase
    end
  end

  assign lr_o = lr_q;

  assert_hi_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN && br_hi_o) |=> lr_q == $past(fa_i) + $past(hi_add));
  assert_ret_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_TGT |=> lr_q == $past(ret_q));
  assert_trim_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_REFILL |=> lr_q == $past(lr_q) - AW'(2));
  assert_other_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN && !grp) |=> $stable(lr_q));
endmodule

// File: rtl/thumb_bl_fetch.sv
module thumb_bl_fetch
  import thumb_bl_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_lo_i,
  input  logic [AW-1:0] tgt_i,
  output seq_st_e       st_o,
  output pipe_op_e      pipe_op_o,
  output logic [AW-1:0] fa_o,
  output logic          seq_o
);
  seq_st_e       st_q;
  logic [AW-1:0] fa_q;
  logic          first_q, jump;

  assign jump = (st_q == ST_RUN) && br_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      fa_q    <= RESET_VEC[AW-1:0];
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          fa_q <= jump ? tgt_i : fa_q + AW'(2);
          st_q <= jump ? ST_TGT : ST_RUN;
        end
        ST_TGT: begin
          fa_q <= fa_q + AW'(2);
          st_q <= ST_REFILL;
        end
        default: begin
          fa_q <= fa_q + AW'(2);
          st_q <= ST_RUN;
        end
      endcase
    end
  end

  always_comb begin
    if (jump)                pipe_op_o = PIPE_FLUSH;
    else if (st_q == ST_TGT) pipe_op_o = PIPE_PRIME;
    else                     pipe_op_o = PIPE_LOAD;
  end

  assign seq_o = !(first_q || jump);
  assign st_o  = st_q;
  assign fa_o  = fa_q;

  assert_linear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !jump) |=> fa_q == $past(fa_q) + AW'(2));
  assert_jump_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump |=> (fa_q == $past(tgt_i)) && seq_o);
  assert_resume_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_REFILL |=> st_q == ST_RUN && seq_o && !first_q);
endmodule

// File: rtl/thumb_bl_seq.sv
module thumb_bl_seq
  import thumb_bl_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          IW        = 16,
  parameter int          OW        = 11,
  parameter logic [31:0] RESET_VEC = 32'h0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   rdata_i,
  output logic [31:0]   addr_o,
  output logic [1:0]    size_o,
  output logic          wr_o,
  output logic          req_no,
  output logic          seq_o,
  output logic          opc_no,
  output logic [31:0]   lr_o
);
  seq_st_e       st;
  pipe_op_e      pipe_op;
  logic [AW-1:0] fa, tgt, lr;
  logic [IW-1:0] ex;
  logic          ex_v, br_hi, br_lo;

  thumb_bl_fetch #(.AW(AW), .RESET_VEC(RESET_VEC)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .br_lo_i   (br_lo),
    .tgt_i     (tgt),
    .st_o      (st),
    .pipe_op_o (pipe_op),
    .fa_o      (fa),
    .seq_o     (seq_o)
  );

  thumb_bl_pipe #(.IW(IW)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (pipe_op),
    .rdata_i (rdata_i[IW-1:0]),
    .ex_o    (ex),
    .ex_v_o  (ex_v)
  );

  thumb_bl_link #(.AW(AW), .IW(IW), .OW(OW)) u_link (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .st_i    (st),
    .fa_i    (fa),
    .ex_i    (ex),
    .ex_v_i  (ex_v),
    .br_hi_o (br_hi),
    .br_lo_o (br_lo),
    .tgt_o   (tgt),
    .lr_o    (lr)
  );

  assign addr_o = fa[31:0];
  assign lr_o   = lr[31:0];
  assign size_o = 2'b01;
  assign wr_o   = 1'b0;
  assign req_no = 1'b0;
  assign opc_no = 1'b0;

  // second half never meets the first half in the same execute slot (R4, R6)
  assert_half_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_hi && br_lo));
  // the non-sequential fetch is followed by the target fetch (R5)
  assert_nonseq_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_o && st == ST_RUN && br_lo) |=> addr_o == $past(tgt[31:0]));
endmodule

// File: tb/thumb_bl_seq_test.sv
module thumb_bl_seq_test;
  localparam int CLK_P = 10;
  localparam int N = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rdata_i;
  logic [31:0] addr_o, lr_o;
  logic [1:0]  size_o;
  logic        wr_o, req_no, seq_o, opc_no;

  logic [15:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;
  assign rdata_i = mem[addr_o[8:1]];

  thumb_bl_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdata_i(rdata_i), .addr_o(addr_o),
    .size_o(size_o), .wr_o(wr_o), .req_no(req_no), .seq_o(seq_o),
    .opc_no(opc_no), .lr_o(lr_o)
  );

  // per-cycle expectation after reset release
  localparam logic [31:0] EXP_ADDR [N] = '{
    32'h0, 32'h2, 32'h4, 32'h6, 32'h8, 32'hA, 32'h88, 32'h8A, 32'h8C, 32'h8E,
    32'h7C, 32'h7E, 32'h80, 32'h82, 32'h84, 32'h86, 32'h88, 32'h8A, 32'h8C, 32'h8E};
  localparam logic EXP_SEQ [N] = '{
    1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] EXP_LR [N] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8, 32'h8, 32'hA, 32'h8, 32'hFFFFF08C,
    32'hFFFFF08C, 32'h8E, 32'h8C, 32'h8C, 32'h8C, 32'h8C, 32'h8C, 32'h8C, 32'h8C,
    32'hFFFFF08C};
  localparam string EXP_REQ [N] = '{
    "R1", "R3 R9", "R3", "R3", "R4", "R5", "R6", "R7", "R8 R7", "R5 R4",
    "R6 R10", "R7", "R8 R10", "R8", "R3", "R3", "R3", "R3", "R4", "R5 R10"};

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_ctrl(input string req);
    check32(req, "ctrl {size,wr,req_n,opc_n}",
            {27'd0, size_o, wr_o, req_no, opc_no}, {27'd0, 2'b01, 3'b000});
  endtask

  task automatic step;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = 16'hE812;           // not a call group: R9
    mem[2]  = 16'hF000;           // first half, high offset 0
    mem[3]  = 16'hF840;           // second half, low offset 0x40 -> 0x88
    mem[68] = 16'hF7FF;           // first half, high offset -1
    mem[69] = 16'hFFF8;           // second half, low offset 0x7F8 -> 0x7C
    // halfwords 0x0..0x2: shift stream so pair sits at 0x4/0x6
    mem[0]  = 16'h0000;
    mem[1]  = 16'hE812;

    repeat (3) @(negedge clk_i);
    // R1: held in reset
    check32("R1", "addr in reset", addr_o, 32'h0);
    check32("R1", "lr in reset", lr_o, 32'h0);
    check32("R1", "seq in reset", {31'd0, seq_o}, 32'd0);
    rst_ni = 1'b1;

    for (int c = 0; c < N; c++) begin
      if (c > 0) step();
      check32(EXP_REQ[c], $sformatf("addr cycle %0d", c), addr_o, EXP_ADDR[c]);
      check32(EXP_REQ[c], $sformatf("seq cycle %0d", c), {31'd0, seq_o}, {31'd0, EXP_SEQ[c]});
      check32(EXP_REQ[c], $sformatf("lr cycle %0d", c), lr_o, EXP_LR[c]);
      check_ctrl("R2");
    end

    // R1: asynchronous reset in the middle of the second call
    #1 rst_ni = 1'b0;
    #1;
    check32("R1", "addr async reset", addr_o, 32'h0);
    check32("R1", "lr async reset", lr_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check32("R1", "first fetch after re-release", addr_o, 32'h0);
    check32("R1", "first seq after re-release", {31'd0, seq_o}, 32'd0);
    step();
    check32("R3", "second fetch after re-release", addr_o, 32'h2);
    check32("R3", "second seq after re-release", {31'd0, seq_o}, 32'd1);
    step();
    step();
    check32("R9", "lr after non-call halfword", lr_o, 32'h0);
    check_ctrl("R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule